// File: doc/BRIEF.md
# Nibble-Wide Double-Rate Link Port

This block is one end of a point-to-point link between two processors. The link has three wires: a 4-bit data bus, a link clock and an acknowledge. One end is set up as the transmitter and the other as the receiver, using a static mode input. Each toggle of the link clock carries one nibble, so data moves on both the rising and the falling link-clock edge. The block's clock runs at that edge rate, which is twice the rate of the processor core. A word of 32 or 48 bits therefore crosses in 8 or 12 block cycles, or 4 or 6 core cycles.

On the parallel side, words enter and leave through a valid/ready handshake, and a width select chooses 32-bit or 48-bit words.
- **Transmit path:** a holding register feeds a shift register that sends the most-significant nibble first.
- **Receive path:** nibbles are shifted into an assembly register. The finished word is handed to an output holding register, so both directions are double-buffered.
- **Flow control:** the receiver raises acknowledge while it can take another whole word. The transmitter checks acknowledge only before a word, and always finishes a word it has started.

In a system, the transmitter's link-clock and data outputs connect to the receiver's link inputs, and the receiver's acknowledge output connects back to the transmitter. The output-enable pins show which wires each end drives.

Top module: `nibble_link`

## Requirements
- R1: Each link-clock toggle carries one 4-bit nibble on the data pins. Once a word has started, the link clock toggles on every block cycle until the word's last nibble, so an 8-nibble word occupies exactly 8 consecutive cycles.
- R2: `wordWide`=0 selects 32-bit words of 8 nibbles: only `txWord[31:0]` is sent, and `rxWord[47:32]` reads zero. `wordWide`=1 selects 48-bit words of 12 nibbles.
- R3: Nibbles leave in order of significance, the most-significant first. In 32-bit mode the first nibble is `txWord[31:28]`; in 48-bit mode it is `txWord[47:44]`.
- R4: The link clock output is high after reset and between words. Every word toggles it an even number of times.
- R5: The transmitter begins a word only in a cycle where `lnkAckI` is high. It completes every word it has begun, regardless of acknowledge.
- R6: The receiver drives `lnkAckO` low exactly when its output holding register is full and a second word is either arriving or parked in the assembly register. A word never arrives while one is parked.
- R7: The receiver raises `rxValid` with the completed word, holds `rxWord` stable until `rxReady` is seen, and delivers words in the order sent, with none lost or repeated.
- R8: On the transmit side, `txReady` is high while the transmit holding register is empty. If the receiving side never drains, exactly three words are accepted: two at the receiver and one in the transmit holding register. The link clock then stays high.
- R9: With `txMode`=1, the block drives the link clock and data (enables high) and does not drive acknowledge, and `rxValid` stays low. With `txMode`=0, the block drives only acknowledge, `txReady` stays low even when `txValid` is high, and the link clock output stays high.
- R10: During reset, `txReady` is high in transmit mode, the link clock output is high, `rxValid` is low and `lnkAckO` is high in receive mode.
- R11: When the transmitter always has a next word and the receiver always drains, the first nibble of each word follows the previous word's last nibble with no idle cycle. Word starts are then spaced by exactly the nibble count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one link-clock edge per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| txMode | input | 1 | 1 = transmitter, 0 = receiver (static) |
| wordWide | input | 1 | 0 = 32-bit words, 1 = 48-bit words (static while traffic flows) |
| txValid | input | 1 | Word offered for transmission |
| txReady | output | 1 | Transmit holding register can take a word |
| txWord | input | 48 | Word to send |
| rxValid | output | 1 | Received word available |
| rxReady | input | 1 | Parallel side takes the received word |
| rxWord | output | 48 | Received word, zero-extended in 32-bit mode |
| lnkClkO | output | 1 | Link clock driven by the transmitter |
| lnkClkOe | output | 1 | Enable for the link clock driver |
| lnkDatO | output | 4 | Link data nibble driven by the transmitter |
| lnkDatOe | output | 1 | Enable for the link data drivers |
| lnkClkI | input | 1 | Link clock seen by the receiver |
| lnkDatI | input | 4 | Link data seen by the receiver |
| lnkAckO | output | 1 | Acknowledge driven by the receiver |
| lnkAckOe | output | 1 | Enable for the acknowledge driver |
| lnkAckI | input | 1 | Acknowledge seen by the transmitter |

## Verification
The hardest state to reach from the ports has the receiver's output register full and a second word parked in its assembly register, with a third word waiting in the transmitter. The link must then stop with the clock high, and it must resume without loss once the receiver drains. The bench reaches this state by running a transmitter looped into a receiver. It first runs random traffic with random back-pressure at both widths, which exercises both the direct hand-off and the parked path. It then turns the receiving sink off entirely while the source keeps offering words, and finally re-enables the sink. A separate phase runs with source and sink always willing, so that word spacing can be measured exactly.

// File: rtl/nlk_pkg.sv
package nlk_pkg;

  // Strobes from the control to the datapath, one per register action.
  typedef struct packed {
    logic txHoldLoad;   // capture parallel word into transmit holding register
    logic txShLoad;     // move holding register into shifter, emit first nibble
    logic txShift;      // emit next nibble from shifter
    logic rxShift;      // shift incoming nibble into assembly register
    logic rxHoldDirect; // last nibble arrives, output register free: write completed word
    logic rxHoldMove;   // parked word moves into freed output register
  } nlk_strobe_t;

endpackage

// File: rtl/nlk_ctrl.sv
module nlk_ctrl
  import nlk_pkg::*;
#(
  parameter int NIB_LONG  = 12,
  parameter int NIB_SHORT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txMode,
  input  logic        wordWide,
  input  logic        txValid,
  output logic        txReady,
  input  logic        lnkAckI,
  output logic        clkOut,
  input  logic        lnkClkI,
  output logic        ackOut,
  output logic        rxValid,
  input  logic        rxReady,
  output nlk_strobe_t strb
);

  localparam int CNT_W = $clog2(NIB_LONG + 1);

  logic [CNT_W-1:0] nibTotal;
  assign nibTotal = wordWide ? CNT_W'(NIB_LONG) : CNT_W'(NIB_SHORT);

  // ---------------- transmit side ----------------
  logic [CNT_W-1:0] txCnt;      // nibbles still to send after the current one
  logic             txHoldFull;
  logic             clkReg;
  logic             txBusy, txAccept, txStart, txStep;

  assign txBusy   = (txCnt != '0);
  assign txReady  = txMode && !txHoldFull;
  assign txAccept = txValid && txReady;
  assign txStart  = txMode && !txBusy && txHoldFull && lnkAckI;
  assign txStep   = txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHoldFull <= 1'b0;
      txCnt      <= '0;
      clkReg     <= 1'b1;
    end else begin
      if (txStart)       txHoldFull <= 1'b0;
      else if (txAccept) txHoldFull <= 1'b1;

      if (txStart)      txCnt <= nibTotal - CNT_W'(1);
      else if (txStep)  txCnt <= txCnt - CNT_W'(1);

      if (txStart || txStep) clkReg <= ~clkReg;
    end
  end

  assign clkOut = clkReg;

  // ---------------- receive side ----------------
  logic [CNT_W-1:0] rxCnt;      // nibbles of the current word already captured
  logic             prevClk;
  logic             asmFull;    // completed word parked in assembly register
  logic             rxHoldFull;
  logic             edgeSeen, lastNib, rxTake, holdFree;
  logic             goDirect, goPark, goMove;

  assign edgeSeen = !txMode && (lnkClkI != prevClk);
  assign lastNib  = edgeSeen && (rxCnt == nibTotal - CNT_W'(1));
  assign rxTake   = rxHoldFull && rxReady;
  assign holdFree = !rxHoldFull || rxTake;
  assign goDirect = lastNib && holdFree;
  assign goPark   = lastNib && !holdFree;
  assign goMove   = asmFull && holdFree && !lastNib;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk    <= 1'b1;
      rxCnt      <= '0;
      asmFull    <= 1'b0;
      rxHoldFull <= 1'b0;
    end else begin
      prevClk <= lnkClkI;

      if (edgeSeen) rxCnt <= lastNib ? '0 : rxCnt + CNT_W'(1);

      if (goPark)      asmFull <= 1'b1;
      else if (goMove) asmFull <= 1'b0;

      if (goDirect || goMove) rxHoldFull <= 1'b1;
      else if (rxTake)        rxHoldFull <= 1'b0;
    end
  end

  assign rxValid = rxHoldFull;
  assign ackOut  = !txMode && !(rxHoldFull && ((rxCnt != '0) || asmFull));

  always_comb begin
    strb              = '0;
    strb.txHoldLoad   = txAccept;
    strb.txShLoad     = txStart;
    strb.txShift      = txStep;
    strb.rxShift      = edgeSeen;
    strb.rxHoldDirect = goDirect;
    strb.rxHoldMove   = goMove;
  end

  // ---------------- assertions ----------------
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txCnt == '0) |-> clkReg)
    else $error("link clock low while no word in progress");

  p_wait_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txMode && !txBusy && !lnkAckI) |=> !txBusy)
    else $error("word begun without acknowledge");

  p_finish_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && (txCnt != CNT_W'(1))) |=> txBusy)
    else $error("word abandoned before its last nibble");

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastNib |-> !asmFull)
    else $error("word arrived while another was parked");

  p_rx_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt < nibTotal)
    else $error("receive nibble count beyond word size");

  p_quiet_clock_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txMode |-> clkReg)
    else $error("receiver toggled its link clock output");

endmodule

// File: rtl/nlk_dpath.sv
module nlk_dpath
  import nlk_pkg::*;
#(
  parameter int WORD_W  = 48,
  parameter int SHORT_W = 32,
  parameter int NIB_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordWide,
  input  nlk_strobe_t       strb,
  input  logic [WORD_W-1:0] txWord,
  input  logic [NIB_W-1:0]  lnkDatI,
  output logic [NIB_W-1:0]  nibOut,
  output logic [WORD_W-1:0] rxWord
);

  localparam int PAD = WORD_W - SHORT_W;
  localparam logic [WORD_W-1:0] SHORT_MASK = {{PAD{1'b0}}, {SHORT_W{1'b1}}};

  function automatic logic [WORD_W-1:0] fitWidth(input logic [WORD_W-1:0] w,
                                                 input logic wide);
    return wide ? w : (w & SHORT_MASK);
  endfunction

  logic [WORD_W-1:0] txHold, txSh, aligned;
  logic [WORD_W-1:0] asmReg, asmNext, rxHold;
  logic [NIB_W-1:0]  nibReg;

  // Short words sit in the low bits; move them to the top so the shifter
  // always emits from its most-significant nibble.
  assign aligned = wordWide ? txHold : (txHold << PAD);
  assign asmNext = {asmReg[WORD_W-NIB_W-1:0], lnkDatI};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
      txSh   <= '0;
      nibReg <= '0;
      asmReg <= '0;
      rxHold <= '0;
    end else begin
      if (strb.txHoldLoad) txHold <= txWord;

      if (strb.txShLoad) begin
        nibReg <= aligned[WORD_W-1 -: NIB_W];
        txSh   <= aligned << NIB_W;
      end else if (strb.txShift) begin
        nibReg <= txSh[WORD_W-1 -: NIB_W];
        txSh   <= txSh << NIB_W;
      end

      if (strb.rxShift) asmReg <= asmNext;

      if (strb.rxHoldDirect)    rxHold <= fitWidth(asmNext, wordWide);
      else if (strb.rxHoldMove) rxHold <= fitWidth(asmReg, wordWide);
    end
  end

  assign nibOut = nibReg;
  assign rxWord = rxHold;

  p_short_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rxHoldDirect || strb.rxHoldMove) && !wordWide)
      |=> (rxWord[WORD_W-1:SHORT_W] == '0))
    else $error("short word delivered with upper bits set");

endmodule

// File: rtl/nibble_link.sv
module nibble_link
  import nlk_pkg::*;
#(
  parameter int WORD_W  = 48,
  parameter int SHORT_W = 32,
  parameter int NIB_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              wordWide,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txWord,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [WORD_W-1:0] rxWord,
  output logic              lnkClkO,
  output logic              lnkClkOe,
  output logic [NIB_W-1:0]  lnkDatO,
  output logic              lnkDatOe,
  input  logic              lnkClkI,
  input  logic [NIB_W-1:0]  lnkDatI,
  output logic              lnkAckO,
  output logic              lnkAckOe,
  input  logic              lnkAckI
);

  localparam int NIB_LONG  = WORD_W / NIB_W;
  localparam int NIB_SHORT = SHORT_W / NIB_W;

  nlk_strobe_t strb;

  nlk_ctrl #(
    .NIB_LONG (NIB_LONG),
    .NIB_SHORT(NIB_SHORT)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .txMode  (txMode),
    .wordWide(wordWide),
    .txValid (txValid),
    .txReady (txReady),
    .lnkAckI (lnkAckI),
    .clkOut  (lnkClkO),
    .lnkClkI (lnkClkI),
    .ackOut  (lnkAckO),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .strb    (strb)
  );

  nlk_dpath #(
    .WORD_W (WORD_W),
    .SHORT_W(SHORT_W),
    .NIB_W  (NIB_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .wordWide(wordWide),
    .strb    (strb),
    .txWord  (txWord),
    .lnkDatI (lnkDatI),
    .nibOut  (lnkDatO),
    .rxWord  (rxWord)
  );

  assign lnkClkOe = txMode;
  assign lnkDatOe = txMode;
  assign lnkAckOe = !txMode;

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxWord)))
    else $error("received word dropped or changed before it was taken");

endmodule

// File: tb/nibble_link_test.sv
module nibble_link_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wide = 1'b0;

  // transmitter instance (uut) parallel side
  logic        tValid = 1'b0;
  logic [47:0] tWord  = '0;
  logic        tReady;
  logic        uRxValid;
  logic [47:0] uRxWord;
  // receiver instance (peer) parallel side
  logic        pRxValid;
  logic        pRxReady = 1'b0;
  logic [47:0] pRxWord;
  logic        pTxValid = 1'b0;
  logic        pTxReady;
  // link wires
  logic        lnkClk, lnkAck;
  logic [3:0]  lnkDat, pDatO;
  logic        uClkOe, uDatOe, uAckOe, uAckO;
  logic        pClkO, pClkOe, pDatOe, pAckOe;

  always #2.5 clk = ~clk;

  nibble_link uut (
    .clk(clk), .rstN(rstN), .txMode(1'b1), .wordWide(wide),
    .txValid(tValid), .txReady(tReady), .txWord(tWord),
    .rxValid(uRxValid), .rxReady(1'b1), .rxWord(uRxWord),
    .lnkClkO(lnkClk), .lnkClkOe(uClkOe), .lnkDatO(lnkDat), .lnkDatOe(uDatOe),
    .lnkClkI(1'b1), .lnkDatI(4'h0),
    .lnkAckO(uAckO), .lnkAckOe(uAckOe), .lnkAckI(lnkAck)
  );

  nibble_link peer (
    .clk(clk), .rstN(rstN), .txMode(1'b0), .wordWide(wide),
    .txValid(pTxValid), .txReady(pTxReady), .txWord(48'h0),
    .rxValid(pRxValid), .rxReady(pRxReady), .rxWord(pRxWord),
    .lnkClkO(pClkO), .lnkClkOe(pClkOe), .lnkDatO(pDatO), .lnkDatOe(pDatOe),
    .lnkClkI(lnkClk), .lnkDatI(lnkDat),
    .lnkAckO(lnkAck), .lnkAckOe(pAckOe), .lnkAckI(1'b0)
  );

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string req, input logic [47:0] got,
                     input logic [47:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // knobs written only by the main process
  int genTarget = 0;
  int srcPct    = 0;
  int sinkPct   = 0;
  bit tputMode  = 1'b0;

  // model state written only by the per-cycle process
  logic [47:0] linkQ[$];
  logic [47:0] rxQ[$];
  int          genIssued = 0;
  int          accepted  = 0;
  int          taken     = 0;
  int          started   = 0;
  int          nibIdx    = 0;
  int          cycle     = 0;
  int          lastStart = -1;
  logic        prevMonClk = 1'b1;
  logic [47:0] curWord = '0;

  function automatic logic [47:0] fit(input logic [47:0] w, input logic wd);
    return wd ? w : {16'h0, w[31:0]};
  endfunction

  // cycle-by-cycle reference model and stimulus, all on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      int          nTot;
      logic [47:0] exp;
      logic [3:0]  expNib;
      logic [63:0] rnd;
      cycle++;
      nTot = wide ? 12 : 8;

      // link monitor: R1 R3 R4 R11
      if (lnkClk != prevMonClk) begin
        if (nibIdx == 0) begin
          if (linkQ.size() == 0) begin
            chk(1'b0, "R5 word without accepted input", 48'h0, 48'h1);
            curWord = '0;
          end else begin
            curWord = linkQ.pop_front();
          end
          started++;
          chk((started - taken) <= 2, "R6 words in receiver", 48'(started - taken), 48'd2);
          if (tputMode && lastStart >= 0)
            chk((cycle - lastStart) == nTot, "R11 word spacing",
                48'(cycle - lastStart), 48'(nTot));
          lastStart = cycle;
        end
        expNib = 4'((curWord >> (4 * (nTot - 1 - nibIdx))) & 48'hF);
        chk(lnkDat == expNib, "R3 nibble order", 48'(lnkDat), 48'(expNib));
        nibIdx++;
        if (nibIdx == nTot) nibIdx = 0;
      end else begin
        chk(nibIdx == 0, "R1 clock stalled inside word", 48'(nibIdx), 48'h0);
        if (nibIdx == 0)
          chk(lnkClk == 1'b1, "R4 idle clock level", 48'(lnkClk), 48'h1);
      end
      prevMonClk = lnkClk;
      if (!tputMode) lastStart = -1;

      // mode-dependent pins: R9
      chk({uClkOe, uDatOe, uAckOe, uRxValid} == 4'b1100, "R9 transmitter pins",
          48'({uClkOe, uDatOe, uAckOe, uRxValid}), 48'hC);
      chk({pClkOe, pDatOe, pAckOe, pClkO, pTxReady} == 5'b00110, "R9 receiver pins",
          48'({pClkOe, pDatOe, pAckOe, pClkO, pTxReady}), 48'h6);

      // source: R8 double buffering on transmit side
      if (!tValid || tReady) begin
        if (genIssued < genTarget && ($urandom % 100) < srcPct) begin
          rnd = {$urandom, $urandom};
          tWord = rnd[47:0];
          tValid = 1'b1;
          genIssued++;
        end else begin
          tValid = 1'b0;
        end
      end
      if (tValid && tReady) begin
        linkQ.push_back(fit(tWord, wide));
        rxQ.push_back(fit(tWord, wide));
        accepted++;
      end

      // sink: R7 R2
      pRxReady = (($urandom % 100) < sinkPct);
      if (pRxValid && pRxReady) begin
        exp = (rxQ.size() != 0) ? rxQ.pop_front() : 48'hDEAD_DEAD_DEAD;
        chk(pRxWord == exp, wide ? "R7 received word" : "R2 received short word",
            pRxWord, exp);
        taken++;
      end
    end
  end

  // watchdog
  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      errs++;
      $display("FAIL watchdog: got %0d expected below 150000", wdog);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic drain();
    while (taken != accepted || nibIdx != 0 || genIssued != genTarget || tValid)
      @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // reset state: R10
    repeat (3) @(negedge clk);
    chk(tReady == 1'b1, "R10 txReady in reset", 48'(tReady), 48'h1);
    chk(lnkClk == 1'b1, "R10 link clock in reset", 48'(lnkClk), 48'h1);
    chk(pRxValid == 1'b0, "R10 rxValid in reset", 48'(pRxValid), 48'h0);
    chk(lnkAck == 1'b1, "R10 acknowledge in reset", 48'(lnkAck), 48'h1);
    @(negedge clk);
    rstN = 1'b1;

    // receiver ignores parallel transmit requests: R9
    pTxValid = 1'b1;

    // random traffic, 32-bit words: R2 R3 R5 R6 R7
    wide = 1'b0; srcPct = 60; sinkPct = 40;
    genTarget += 40;
    drain();

    // random traffic, 48-bit words
    wide = 1'b1; srcPct = 70; sinkPct = 30;
    genTarget += 40;
    drain();

    // full throughput, 48-bit words: R11
    tputMode = 1'b1; srcPct = 100; sinkPct = 100;
    genTarget += 12;
    drain();
    tputMode = 1'b0;

    // stall: receiver never drains: R8 R6
    wide = 1'b0; srcPct = 100; sinkPct = 0;
    genTarget += 5;
    repeat (200) @(negedge clk);
    chk(accepted - taken == 3, "R8 words accepted while stalled",
        48'(accepted - taken), 48'd3);
    chk(tReady == 1'b0, "R8 txReady while stalled", 48'(tReady), 48'h0);
    chk(started - taken == 2, "R6 words at receiver while stalled",
        48'(started - taken), 48'd2);
    chk(lnkAck == 1'b0, "R6 acknowledge while stalled", 48'(lnkAck), 48'h0);
    chk(pRxValid == 1'b1, "R7 word held while stalled", 48'(pRxValid), 48'h1);
    chk(lnkClk == 1'b1, "R4 clock parked high while stalled", 48'(lnkClk), 48'h1);
    sinkPct = 100;
    drain();
    chk(taken == accepted && rxQ.size() == 0, "R7 all words delivered",
        48'(taken), 48'(accepted));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule